// File: doc/BRIEF.md
# Non-Maskable Interrupt Aggregator with Escalation Watchdog

This block collects error events for one CPU and turns them into a non-maskable interrupt. A communication-bus error and the built-in self-test failures of two cores (the local core and a peer core) each latch into a sticky source flag. When the global enable is set and any source flag is latched, a summary flag sets and drives the interrupt line. At the same time a watchdog counter starts. If software leaves the sources latched until the counter reaches a programmable period, the block issues a one-cycle reset request.

Software uses four word registers through a simple write strobe and a combinational read port: address 0 is configuration, address 1 holds the flags, address 2 clears flags, and address 3 holds the watchdog period. The global enable and the bus-error enable can only be set. There are two reset inputs. The device reset clears everything. The CPU-local reset clears the configuration, the period and the watchdog, but it leaves the flags in place so that software can find the cause after it restarts.

Top module: `nmi_hub`

## Requirements
- R1: Configuration bit 0 (global enable) is set by writing 1 to address 0. Writing 0 leaves it set. Either reset clears it.
- R2: Configuration bit 6 (bus-error enable) is also set-only and reads 0 after either reset. A bus-error event latches into flag bit 1 only while this bit is 1.
- R3: A timeout or a signature-mismatch report from the local core sets flag bit 5. The same report from the peer core sets flag bit 4. Configuration bits 5 and 4 mirror these two flags as read-only bits, and writes to address 0 never clear them.
- R4: A write to address 2 clears every flag whose bit is 1 in the written data, using the same bit positions as address 1. Address 2 always reads 0.
- R5: If a source event arrives in the same cycle as a clear of its flag, the flag stays set.
- R6: With the global enable at 1, the summary flag (address 1 bit 0) sets on the clock edge after a source flag appears. The interrupt output follows the summary flag while the global enable is 1.
- R7: After the summary flag has been raised, it does not set again until it and all source flags have been 0 in the same cycle.
- R8: The watchdog counts clock edges while the global enable is 1 and any source flag is latched. For an event sampled at edge k and a period P, the reset request is high for exactly the one cycle that follows edge k+P. After that the count holds and no further requests are made until the sources are cleared.
- R9: When no source flag is latched, the count returns to 0. A new event therefore restarts the full period.
- R10: The source flags and the summary flag are reset only by the device reset and survive the CPU-local reset. The enables, the period and the watchdog are reset by either reset.
- R11: Address 3 is a 16-bit period register that reads back what was written and resets to all ones. A period of 0 never produces a reset request.
- R12: Configuration bits 3:1 and 15:7 read 0 and ignore writes. Flag-register bits other than 0, 1, 4 and 5 read 0.
- R13: While the global enable is 0, source flags still latch, but the interrupt output stays low and the watchdog does not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dev_rst_n | input | 1 | Full device reset, active low, asynchronous |
| cpu_rst_n | input | 1 | CPU-local system reset, active low, asynchronous |
| bus_err_evt | input | 1 | Communication-bus error event |
| bist_loc_tmo | input | 1 | Local core self-test timeout |
| bist_loc_sig | input | 1 | Local core self-test signature mismatch |
| bist_peer_tmo | input | 1 | Peer core self-test timeout |
| bist_peer_sig | input | 1 | Peer core self-test signature mismatch |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| nmi_out | output | 1 | Non-maskable interrupt to the CPU |
| rst_req | output | 1 | One-cycle reset request from the watchdog |

## Verification
The bench writes every combination of the low seven configuration bits and then writes zeros. A design that let a 0 clear an enable, or that stored a reserved bit, returns the wrong readback. The watchdog is swept over several short periods for every event input, and the bench counts the cycle of the request and how many request cycles occur. An off-by-one compare, a counter that does not restart from zero, or a repeating request shows up as a wrong count. The bench also tests a clear that collides with an event, a summary cleared while its sources are still latched, and a CPU-local reset with flags pending. A design that lets the clear win, re-fires the interrupt early, or wipes the flags on the local reset fails these checks.

// File: rtl/nmi_hub_pkg.sv
package nmi_hub_pkg;

   // source indices
   localparam int unsigned NSRC     = 3;
   localparam int unsigned SRC_BUS  = 0;
   localparam int unsigned SRC_PEER = 1;
   localparam int unsigned SRC_LOC  = 2;

   // register word addresses
   localparam int unsigned ADR_CFG = 0;
   localparam int unsigned ADR_FLG = 1;
   localparam int unsigned ADR_CLR = 2;
   localparam int unsigned ADR_PER = 3;

   // configuration and flag bit positions
   localparam int unsigned CFG_EN_BIT    = 0;
   localparam int unsigned CFG_BUSEN_BIT = 6;
   localparam int unsigned SUM_BIT       = 0;
   localparam int unsigned TOP_USED_BIT  = 6;

   // bit position of each source in the flag and clear registers
   function automatic int unsigned src_bit(input int idx);
      case (idx)
         0:       return 1;
         1:       return 4;
         default: return 5;
      endcase
   endfunction

endpackage

// File: rtl/nmi_sticky.sv
module nmi_sticky #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   // set has priority over clear so a colliding event is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end

endmodule

// File: rtl/nmi_wdog.sv
module nmi_wdog #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             req_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_nx;
   assign cnt_nx = cnt_o + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         req_o <= 1'b0;
      end else begin
         req_o <= 1'b0;
         if (!run_i) begin
            cnt_o <= '0;
         end else if (cnt_o != period_i) begin
            cnt_o <= cnt_nx;
            req_o <= (cnt_nx == period_i);
         end
      end
   end

endmodule

// File: rtl/nmi_hub.sv
module nmi_hub #(
   parameter int unsigned      DATA_W     = 16,
   parameter int unsigned      ADDR_W     = 2,
   parameter int unsigned      CNT_W      = 16,
   parameter logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}}
) (
   input  logic              clk,
   input  logic              dev_rst_n,
   input  logic              cpu_rst_n,
   input  logic              bus_err_evt,
   input  logic              bist_loc_tmo,
   input  logic              bist_loc_sig,
   input  logic              bist_peer_tmo,
   input  logic              bist_peer_sig,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              nmi_out,
   output logic              rst_req
);
   import nmi_hub_pkg::*;

   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADR_CFG);
   localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(ADR_FLG);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADR_CLR);
   localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(ADR_PER);

   // elaboration checks
   if (DATA_W <= TOP_USED_BIT) begin : g_bad_data_w
      $error("nmi_hub: DATA_W too narrow for the register layout");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("nmi_hub: CNT_W must not exceed DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("nmi_hub: ADDR_W must cover four registers");
   end

   logic sys_rst_n;
   assign sys_rst_n = dev_rst_n & cpu_rst_n;

   logic wr_cfg, wr_clr, wr_per;
   assign wr_cfg = reg_wr && (reg_addr == A_CFG);
   assign wr_clr = reg_wr && (reg_addr == A_CLR);
   assign wr_per = reg_wr && (reg_addr == A_PER);

   // configuration, local reset domain
   logic             gen_en_q, bus_en_q;
   logic [CNT_W-1:0] period_q;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         gen_en_q <= 1'b0;
         bus_en_q <= 1'b0;
         period_q <= PERIOD_RST;
      end else begin
         if (wr_cfg) begin
            gen_en_q <= gen_en_q | reg_wdata[CFG_EN_BIT];
            bus_en_q <= bus_en_q | reg_wdata[CFG_BUSEN_BIT];
         end
         if (wr_per) period_q <= reg_wdata[CNT_W-1:0];
      end
   end

   // source flags, device reset domain
   logic [NSRC-1:0] src_set, src_clr, src_flag;
   assign src_set[SRC_BUS]  = bus_err_evt & bus_en_q;
   assign src_set[SRC_PEER] = bist_peer_tmo | bist_peer_sig;
   assign src_set[SRC_LOC]  = bist_loc_tmo | bist_loc_sig;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      assign src_clr[gi] = wr_clr & reg_wdata[src_bit(gi)];
      nmi_sticky #(.RST_VAL(1'b0)) u_flag (
         .clk   (clk),
         .rst_n (dev_rst_n),
         .set_i (src_set[gi]),
         .clr_i (src_clr[gi]),
         .q_o   (src_flag[gi])
      );
   end

   logic any_src;
   assign any_src = |src_flag;

   // summary flag and re-arm latch, device reset domain
   logic sum_q, sum_set, armed_q;
   assign sum_set = gen_en_q & any_src & armed_q & ~sum_q;

   nmi_sticky #(.RST_VAL(1'b0)) u_sum (
      .clk   (clk),
      .rst_n (dev_rst_n),
      .set_i (sum_set),
      .clr_i (wr_clr & reg_wdata[SUM_BIT]),
      .q_o   (sum_q)
   );

   always_ff @(posedge clk or negedge dev_rst_n) begin
      if (!dev_rst_n)              armed_q <= 1'b1;
      else if (sum_set)            armed_q <= 1'b0;
      else if (!sum_q && !any_src) armed_q <= 1'b1;
   end

   assign nmi_out = sum_q & gen_en_q;

   // escalation watchdog
   logic [CNT_W-1:0] wd_cnt;
   nmi_wdog #(.CNT_W(CNT_W)) u_wdog (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .run_i    (gen_en_q & any_src),
      .period_i (period_q),
      .cnt_o    (wd_cnt),
      .req_o    (rst_req)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CFG: begin
            reg_rdata[CFG_EN_BIT]        = gen_en_q;
            reg_rdata[CFG_BUSEN_BIT]     = bus_en_q;
            reg_rdata[src_bit(SRC_PEER)] = src_flag[SRC_PEER];
            reg_rdata[src_bit(SRC_LOC)]  = src_flag[SRC_LOC];
         end
         A_FLG: begin
            reg_rdata[SUM_BIT] = sum_q;
            for (int i = 0; i < NSRC; i++) reg_rdata[src_bit(i)] = src_flag[i];
         end
         A_PER:   reg_rdata[CNT_W-1:0] = period_q;
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/nmi_hub_chk.sv
module nmi_hub_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              dev_rst_n,
   input logic              sys_rst_n,
   input logic              gen_en,
   input logic              bus_en,
   input logic [2:0]        src_set,
   input logic [2:0]        src_flag,
   input logic              any_src,
   input logic [CNT_W-1:0]  wd_cnt,
   input logic              rst_req,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata
);
   import nmi_hub_pkg::*;

   assert_en_setonly_R1: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !$fell(gen_en));

   assert_busen_setonly_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !$fell(bus_en));

   assert_set_wins_bus_R5: assert property (@(posedge clk) disable iff (!dev_rst_n)
      src_set[0] |=> src_flag[0]);

   assert_set_wins_peer_R5: assert property (@(posedge clk) disable iff (!dev_rst_n)
      src_set[1] |=> src_flag[1]);

   assert_set_wins_loc_R5: assert property (@(posedge clk) disable iff (!dev_rst_n)
      src_set[2] |=> src_flag[2]);

   assert_clr_reads_zero_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (reg_addr == ADDR_W'(ADR_CLR)) |-> (reg_rdata == '0));

   assert_req_one_cycle_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      rst_req |=> !rst_req);

   assert_cnt_idle_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !any_src |=> (wd_cnt == '0));

   assert_cnt_disabled_R13: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !gen_en |=> (wd_cnt == '0));

   assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (reg_addr == ADDR_W'(ADR_CFG)) |-> ((reg_rdata[3:1] == 3'b000) && ((reg_rdata >> 7) == '0)));

endmodule

bind nmi_hub nmi_hub_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .dev_rst_n (dev_rst_n),
   .sys_rst_n (sys_rst_n),
   .gen_en    (gen_en_q),
   .bus_en    (bus_en_q),
   .src_set   (src_set),
   .src_flag  (src_flag),
   .any_src   (any_src),
   .wd_cnt    (wd_cnt),
   .rst_req   (rst_req),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata)
);

// File: tb/nmi_hub_test.sv
module nmi_hub_test;

   logic        clk = 1'b0;
   logic        dev_rst_n = 1'b0;
   logic        cpu_rst_n = 1'b0;
   logic        bus_err_evt = 1'b0;
   logic        bist_loc_tmo = 1'b0;
   logic        bist_loc_sig = 1'b0;
   logic        bist_peer_tmo = 1'b0;
   logic        bist_peer_sig = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        nmi_out;
   logic        rst_req;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nmi_hub uut (
      .clk           (clk),
      .dev_rst_n     (dev_rst_n),
      .cpu_rst_n     (cpu_rst_n),
      .bus_err_evt   (bus_err_evt),
      .bist_loc_tmo  (bist_loc_tmo),
      .bist_loc_sig  (bist_loc_sig),
      .bist_peer_tmo (bist_peer_tmo),
      .bist_peer_sig (bist_peer_sig),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .nmi_out       (nmi_out),
      .rst_req       (rst_req)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 16'h0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic drive_src(input int s, input logic v);
      case (s)
         0:       bus_err_evt   = v;
         1:       bist_loc_tmo  = v;
         2:       bist_loc_sig  = v;
         3:       bist_peer_tmo = v;
         default: bist_peer_sig = v;
      endcase
   endtask

   // expected flag bit for each stimulus source
   function automatic logic [15:0] src_mask(input int s);
      case (s)
         0:       return 16'h0002;
         1, 2:    return 16'h0020;
         default: return 16'h0010;
      endcase
   endfunction

   task automatic pulse(input int s);
      @(negedge clk); drive_src(s, 1'b1);
      @(negedge clk); drive_src(s, 1'b0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cpu_reset();
      @(negedge clk); cpu_rst_n = 1'b0;
      @(negedge clk); cpu_rst_n = 1'b1;
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int first, highs;
      idle(3);
      dev_rst_n = 1'b1; cpu_rst_n = 1'b1;
      idle(1);

      // R10 R11 reset state
      rd(0, d); chk("R10 cfg after reset", d, 16'h0000);
      rd(1, d); chk("R10 flags after reset", d, 16'h0000);
      rd(2, d); chk("R4 clear reads 0", d, 16'h0000);
      rd(3, d); chk("R11 period reset value", d, 16'hFFFF);
      chk("R6 nmi after reset", {15'h0, nmi_out}, 16'h0);
      chk("R8 req after reset", {15'h0, rst_req}, 16'h0);

      // R1 R2 R12 sweep of configuration writes
      for (int v = 0; v < 128; v++) begin
         logic [15:0] e;
         cpu_reset();
         e = 16'(v) & 16'h0041;
         wr(0, 16'hFF80 | 16'(v));
         rd(0, d); chk("R12 R1 R2 cfg write", d, e);
         wr(0, 16'h0000);
         rd(0, d); chk("R1 R2 zero write ignored", d, e);
      end
      cpu_reset();
      rd(0, d); chk("R1 enables cleared by local reset", d, 16'h0000);

      // R11 period readback
      wr(3, 16'hA5C3);
      rd(3, d); chk("R11 period readback", d, 16'hA5C3);

      // R13 disabled: flag latches, no nmi, no request
      wr(3, 16'd3);
      pulse(1);
      highs = 0;
      for (int c = 0; c < 10; c++) begin
         if (rst_req || nmi_out) highs++;
         idle(1);
      end
      chk("R13 no nmi or request while disabled", 16'(highs), 16'd0);
      rd(1, d); chk("R13 R3 flag latched while disabled", d, 16'h0020);
      rd(0, d); chk("R3 cfg mirror of local flag", d, 16'h0020);
      wr(2, 16'h0020);
      rd(1, d); chk("R4 clear local flag", d, 16'h0000);

      // R2 bus error ignored while bus enable is 0
      pulse(0); idle(2);
      rd(1, d); chk("R2 bus event ignored when disabled", d, 16'h0000);

      // R6 R8 R9 watchdog sweep
      wr(0, 16'h0041);
      for (int p = 1; p <= 6; p++) begin
         for (int s = 0; s < 5; s++) begin
            wr(3, 16'(p));
            pulse(s);
            chk("R6 nmi not yet", {15'h0, nmi_out}, 16'h0);
            first = 0; highs = 0;
            for (int c = 1; c <= p + 5; c++) begin
               if (c == 2) chk("R6 nmi raised", {15'h0, nmi_out}, 16'h1);
               if (rst_req) begin
                  highs++;
                  if (first == 0) first = c;
               end
               idle(1);
            end
            chk("R8 R9 request cycle", 16'(first), 16'(p + 1));
            chk("R8 single request", 16'(highs), 16'd1);
            rd(1, d); chk("R3 R2 R6 flags", d, 16'h0001 | src_mask(s));
            wr(2, 16'hFFFF);
            rd(1, d); chk("R4 clear all", d, 16'h0000);
            idle(2);
            chk("R6 nmi low after clear", {15'h0, nmi_out}, 16'h0);
         end
      end

      // R11 period zero never requests
      wr(3, 16'h0000);
      pulse(2);
      highs = 0;
      for (int c = 0; c < 20; c++) begin
         if (rst_req) highs++;
         idle(1);
      end
      chk("R11 period zero no request", 16'(highs), 16'd0);
      wr(2, 16'hFFFF);

      // R7 re-arm rule
      wr(3, 16'hFFFF);
      pulse(3); idle(1);
      chk("R7 first nmi", {15'h0, nmi_out}, 16'h1);
      wr(2, 16'h0001); idle(3);
      rd(1, d); chk("R7 summary stays clear with source latched", d, 16'h0010);
      chk("R7 nmi low", {15'h0, nmi_out}, 16'h0);
      pulse(4); idle(2);
      chk("R7 no re-fire on repeat event", {15'h0, nmi_out}, 16'h0);
      wr(2, 16'h0010);
      pulse(1); idle(1);
      chk("R7 re-fire after full clear", {15'h0, nmi_out}, 16'h1);

      // R5 set wins over clear
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0020; bist_loc_sig = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 16'h0; bist_loc_sig = 1'b0;
      rd(1, d); chk("R5 local set beats clear", d & 16'h0020, 16'h0020);
      pulse(3);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0010; bist_peer_tmo = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 16'h0; bist_peer_tmo = 1'b0;
      rd(1, d); chk("R5 peer set beats clear", d & 16'h0010, 16'h0010);

      // R3 configuration writes do not clear flags
      wr(0, 16'h0000);
      wr(0, 16'hFFFF);
      rd(1, d); chk("R3 cfg writes keep flags", d, 16'h0031);
      rd(2, d); chk("R4 clear reads 0 with flags set", d, 16'h0000);

      // R10 local reset keeps flags, device reset clears them
      wr(3, 16'h0055);
      cpu_reset();
      rd(1, d); chk("R10 flags survive local reset", d, 16'h0031);
      rd(0, d); chk("R10 cfg after local reset", d, 16'h0030);
      rd(3, d); chk("R10 period after local reset", d, 16'hFFFF);
      chk("R10 nmi low after local reset", {15'h0, nmi_out}, 16'h0);
      @(negedge clk); dev_rst_n = 1'b0;
      @(negedge clk); dev_rst_n = 1'b1;
      rd(1, d); chk("R10 flags cleared by device reset", d, 16'h0000);
      rd(0, d); chk("R10 cfg cleared by device reset", d, 16'h0000);

      done = 1'b1;
      report();
      $finish;
   end

endmodule